// File: doc/BRIEF.md
# Programmable Watchdog and Interval Timer

This block supervises software with a 16-bit down counter. The counter advances on a tick made by two dividers in series. The first is a programmable prescaler that divides the main clock by (prescale + 1). The second divides the result by a fixed factor of 16, 32, 64 or 128. The timeout is therefore the loaded count multiplied by the tick period.

When the counter expires it reloads from a reload register and keeps counting. Expiry can pulse an interrupt, start a system reset pulse lasting exactly 128 main-clock cycles, or do both. With reset generation off, the block serves as an ordinary periodic interval timer.

Software reaches the block through three word registers. The control word is at address 0, the reload value at address 1 and the live count at address 2. Software services the watchdog by writing the count register before it runs out.

Top module: `guard_timer`

## Requirements
- R1: After reset, control reads 0x0005 (run on, interrupt off, reset generation on, factor 16, prescale 0), reload and count both read 0x8000, and irq_o and sys_rst_o are low.
- R2: Control fields are: bit 0 run, bit 1 interrupt enable, bit 2 reset enable, bits [4:3] factor select (0→16, 1→32, 2→64, 3→128), bits [7:5] read as zero, and bits [15:8] prescale. While running, the count falls by one every (prescale+1)×factor cycles.
- R3: Expiry happens on a tick that finds the count at 1 or 0. Expiry loads the count from the reload register and, with interrupt enable set, drives irq_o high for one cycle. After count N is written, expiry comes N×(prescale+1)×factor cycles later.
- R4: With reset enable set, an expiry drives sys_rst_o high for exactly 128 consecutive cycles, starting in the same cycle as the interrupt.
- R5: With reset enable clear, expiry never asserts sys_rst_o, while interrupts still occur.
- R6: Clearing run freezes the count and the tick divider. Setting it again resumes counting.
- R7: A write to the count register loads the count at the next edge and restarts the tick divider, whether or not the block is running. Rewriting the count before expiry postpones the expiry.
- R8: An expiry while sys_rst_o is already high neither lengthens nor restarts the pulse.
- R9: Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | main clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | 2 | register address |
| bus_wdata | input | 16 | write data |
| bus_rdata | output | 16 | read data, combinational from bus_addr |
| irq_o | output | 1 | one-cycle expiry interrupt |
| sys_rst_o | output | 1 | 128-cycle system reset pulse |

## Verification
The assertions take for granted that the shortest tick period is 16 cycles. This holds at every prescale and factor setting, so two expiries can never fall on adjacent cycles. They also take for granted that bus writes are single-cycle strobes with a settled address. The stimulus writes a new count only while the block is stopped or well away from a tick that would expire it. It changes divider settings only while the counter is stopped, so every expected expiry cycle follows from the write edges alone.

// File: rtl/gtm_pkg.sv
package gtm_pkg;

    localparam int DATA_W      = 16;
    localparam int PRESCALE_W  = 8;
    localparam int PULSE_LEN   = 128;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_RELOAD = 2'd1,
        ADDR_COUNT  = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PRESCALE_W-1:0] prescale;
        logic [2:0]            spare;
        logic [1:0]            div_sel;
        logic                  rst_en;
        logic                  irq_en;
        logic                  run;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{prescale: '0, spare: '0, div_sel: 2'd0,
                                     rst_en: 1'b1, irq_en: 1'b0, run: 1'b1};
    localparam logic [DATA_W-1:0] COUNT_RESET = 16'h8000;

    function automatic logic [7:0] div_factor(input logic [1:0] sel);
        return 8'd16 << sel;
    endfunction

endpackage

// File: rtl/gtm_regs.sv
module gtm_regs
    import gtm_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    input  logic [W-1:0] count,
    output logic [W-1:0] bus_rdata,
    output ctrl_t        ctrl,
    output logic [W-1:0] reload,
    output logic         count_load
);

    reg_addr_e addr;
    assign addr = reg_addr_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= CTRL_RESET;
            reload <= COUNT_RESET;
        end else if (bus_wr) begin
            if (addr == ADDR_CTRL) begin
                ctrl       <= ctrl_t'(bus_wdata);
                ctrl.spare <= '0;
            end
            if (addr == ADDR_RELOAD) begin
                reload <= bus_wdata;
            end
        end
    end

    assign count_load = bus_wr && (addr == ADDR_COUNT);

    always_comb begin
        case (addr)
            ADDR_CTRL:   bus_rdata = W'(ctrl);
            ADDR_RELOAD: bus_rdata = reload;
            ADDR_COUNT:  bus_rdata = count;
            default:     bus_rdata = '0;
        endcase
    end

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_wr && addr == ADDR_CTRL |=> ctrl.spare == 3'd0);  // R2

endmodule

// File: rtl/gtm_divider.sv
module gtm_divider
    import gtm_pkg::*;
#(
    parameter int PW = PRESCALE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    input  logic [PW-1:0] prescale,
    input  logic [1:0]    div_sel,
    output logic          tick
);

    logic [PW-1:0] pre_cnt;
    logic [7:0]    stg_cnt;
    logic [7:0]    stg_top;
    logic          pre_last;
    logic          stg_last;

    assign stg_top  = 8'(div_factor(div_sel) - 8'd1);
    assign pre_last = pre_cnt >= prescale;
    assign stg_last = stg_cnt >= stg_top;
    assign tick     = run && !clear && pre_last && stg_last;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pre_cnt <= '0;
            stg_cnt <= '0;
        end else if (run) begin
            if (pre_last) begin
                pre_cnt <= '0;
                stg_cnt <= stg_last ? 8'd0 : 8'(stg_cnt + 8'd1);
            end else begin
                pre_cnt <= PW'(pre_cnt + 1'b1);
            end
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);  // R2

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run && !clear |=> $stable(pre_cnt) && $stable(stg_cnt));  // R6

endmodule

// File: rtl/gtm_counter.sv
module gtm_counter
    import gtm_pkg::*;
#(
    parameter int W = DATA_W,
    parameter logic [W-1:0] INIT = COUNT_RESET
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         fire
);

    assign fire = tick && !load && (count <= W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= INIT;
        end else if (load) begin
            count <= load_val;
        end else if (fire) begin
            count <= reload;
        end else if (tick) begin
            count <= W'(count - 1'b1);
        end
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        tick && !load && count > W'(1) |=> count == W'($past(count) - 1'b1));  // R2

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !run && !load |=> $stable(count));  // R6

    AST_LOAD_NOW: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));  // R7

    AST_RELOAD_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire |=> count == $past(reload));  // R3

endmodule

// File: rtl/gtm_rstpulse.sv
module gtm_rstpulse
    import gtm_pkg::*;
#(
    parameter int LEN = PULSE_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic enable,
    output logic pulse
);

    localparam int RW = $clog2(LEN + 1);

    logic [RW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= RW'(remain - 1'b1);
        end else if (fire && enable) begin
            remain <= RW'(LEN);
        end
    end

    assign pulse = remain != '0;

    logic [RW:0] high_len;
    always_ff @(posedge clk) begin
        if (rst)        high_len <= '0;
        else if (pulse) high_len <= (RW+1)'(high_len + 1'b1);
        else            high_len <= '0;
    end

    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse) |-> high_len == (RW+1)'(LEN));  // R4

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(fire && enable));  // R4

    AST_NO_EXTEND: assert property (@(posedge clk) disable iff (rst)
        high_len >= (RW+1)'(LEN) |-> !pulse);  // R8

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import gtm_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int PW     = PRESCALE_W,
    parameter int RSTLEN = PULSE_LEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    output logic         irq_o,
    output logic         sys_rst_o
);

    ctrl_t        ctrl;
    logic [W-1:0] reload;
    logic [W-1:0] count;
    logic         count_load;
    logic         tick;
    logic         fire;

    gtm_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count      (count),
        .bus_rdata  (bus_rdata),
        .ctrl       (ctrl),
        .reload     (reload),
        .count_load (count_load)
    );

    gtm_divider #(.PW(PW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .clear    (count_load),
        .prescale (ctrl.prescale),
        .div_sel  (ctrl.div_sel),
        .tick     (tick)
    );

    gtm_counter #(.W(W), .INIT(W'(COUNT_RESET))) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl.run),
        .tick     (tick),
        .load     (count_load),
        .load_val (bus_wdata),
        .reload   (reload),
        .count    (count),
        .fire     (fire)
    );

    gtm_rstpulse #(.LEN(RSTLEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .enable (ctrl.rst_en),
        .pulse  (sys_rst_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= fire && ctrl.irq_en;
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);  // R3

    AST_TIMER_ONLY: assert property (@(posedge clk) disable iff (rst)
        !ctrl.rst_en && !sys_rst_o |=> !sys_rst_o);  // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !ctrl.irq_en |=> !irq_o);  // R3

endmodule

// File: tb/guard_timer_test.sv
module guard_timer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;
    logic        sys_rst_o;

    guard_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_irq[$];
    int exp_rst[$];
    int rst_rises = 0;
    int rst_start = 0;
    bit rst_prev  = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d, output int edge_no);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        edge_no = cyc;
    endtask

    task automatic bus_read(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // monitor: compare design events against scoreboard queues
    always @(negedge clk) begin
        if (!rst) begin
            if (irq_o) begin
                if (exp_irq.size() == 0) begin
                    check(1'b0, "R3 unexpected irq", cyc, -1);
                end else begin
                    int e;
                    e = exp_irq.pop_front();
                    check(cyc == e, "R3 irq cycle", cyc, e);
                end
            end
            if (sys_rst_o && !rst_prev) begin
                rst_rises++;
                rst_start = cyc;
                if (exp_rst.size() == 0) begin
                    check(1'b0, "R5 unexpected reset pulse", cyc, -1);
                end else begin
                    int e;
                    e = exp_rst.pop_front();
                    check(cyc == e, "R4 reset pulse start", cyc, e);
                end
            end
            if (!sys_rst_o && rst_prev) begin
                check(cyc - rst_start == 128, "R4 R8 reset pulse length", cyc - rst_start, 128);
            end
            rst_prev = sys_rst_o;
        end
    end

    task automatic run_all();
        int v, w, w2, r, w3, w4, c, c2, c3, f, fv, d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, v); check(v == 16'h0005, "R1 ctrl reset", v, 16'h0005);
        bus_read(2'd1, v); check(v == 16'h8000, "R1 reload reset", v, 16'h8000);
        bus_read(2'd2, v); check(v == 16'h8000, "R1 count reset", v, 16'h8000);
        check(irq_o == 1'b0 && sys_rst_o == 1'b0, "R1 outputs low", int'({irq_o, sys_rst_o}), 0);
        // R9 address 3
        bus_read(2'd3, v); check(v == 0, "R9 addr3 reads zero", v, 0);

        // R2 R3 R5: prescale 1, factor 16 -> 32 cycles per tick, timer only
        bus_write(2'd0, 16'h0103, d);
        bus_write(2'd1, 16'd3, d);
        bus_write(2'd2, 16'd5, w);
        bus_read(2'd2, v); check(v == 5, "R7 count loaded", v, 5);
        exp_irq.push_back(w + 160);
        exp_irq.push_back(w + 256);
        wait_until(w + 63);
        bus_read(2'd2, v); check(v == 4, "R2 count before second tick", v, 4);
        wait_until(w + 64);
        bus_read(2'd2, v); check(v == 3, "R2 count after two ticks", v, 3);
        wait_until(w + 256);
        bus_read(2'd2, v); check(v == 3, "R3 reload after expiry", v, 3);
        wait_until(w + 260);
        check(exp_irq.size() == 0, "R3 all expiries seen", exp_irq.size(), 0);
        check(rst_rises == 0, "R5 no reset pulse in timer mode", rst_rises, 0);

        // R6 freeze
        bus_write(2'd0, 16'h0102, f);
        bus_read(2'd2, fv);
        wait_until(f + 200);
        bus_read(2'd2, v); check(v == fv, "R6 count frozen", v, fv);
        check(exp_irq.size() == 0, "R6 no irq while stopped", exp_irq.size(), 0);
        bus_write(2'd2, 16'd2, w2);
        bus_read(2'd2, v); check(v == 2, "R7 load while stopped", v, 2);
        bus_write(2'd0, 16'h0103, r);
        exp_irq.push_back(r + 64);
        wait_until(r + 32);
        bus_read(2'd2, v); check(v == 1, "R6 resumes after run set", v, 1);

        // R7 servicing postpones expiry
        wait_until(r + 70);
        bus_write(2'd2, 16'd4, w3);
        wait_until(w3 + 100);
        bus_write(2'd2, 16'd4, w4);
        exp_irq.push_back(w4 + 128);
        wait_until(w4 + 130);
        bus_write(2'd0, 16'h0102, d);
        check(exp_irq.size() == 0, "R7 postponed expiry seen", exp_irq.size(), 0);

        // R4 R8 reset pulse: prescale 0, factor 16, reload 2
        bus_write(2'd1, 16'd2, d);
        bus_write(2'd2, 16'd1, d);
        bus_write(2'd0, 16'h0007, c);
        for (int k = 0; k < 6; k++) exp_irq.push_back(c + 16 + 32 * k);
        exp_rst.push_back(c + 16);
        exp_rst.push_back(c + 176);
        wait_until(c + 100);
        check(sys_rst_o == 1'b1, "R8 pulse held through repeat expiry", int'(sys_rst_o), 1);
        wait_until(c + 180);
        bus_write(2'd0, 16'h0006, d);
        wait_until(c + 320);
        check(exp_irq.size() == 0, "R4 irqs alongside pulses", exp_irq.size(), 0);
        check(exp_rst.size() == 0, "R8 second pulse after first ends", exp_rst.size(), 0);
        check(sys_rst_o == 1'b0, "R4 pulse ended", int'(sys_rst_o), 0);

        // R2 factor 64, prescale 2 -> 192 cycles per tick
        bus_write(2'd2, 16'd10, d);
        bus_write(2'd0, 16'h0211, c2);
        wait_until(c2 + 191);
        bus_read(2'd2, v); check(v == 10, "R2 x64 before tick", v, 10);
        wait_until(c2 + 192);
        bus_read(2'd2, v); check(v == 9, "R2 x64 at tick", v, 9);
        bus_write(2'd0, 16'h0010, d);

        // R2 factor 128, prescale 0
        bus_write(2'd2, 16'd10, d);
        bus_write(2'd0, 16'h0019, c3);
        wait_until(c3 + 127);
        bus_read(2'd2, v); check(v == 10, "R2 x128 before tick", v, 10);
        wait_until(c3 + 128);
        bus_read(2'd2, v); check(v == 9, "R2 x128 at tick", v, 9);
        bus_write(2'd0, 16'h0018, d);

        // R9 write to address 3 ignored
        bus_write(2'd3, 16'hFFFF, d);
        bus_read(2'd0, v); check(v == 16'h0018, "R9 ctrl unchanged", v, 16'h0018);
        bus_read(2'd1, v); check(v == 2, "R9 reload unchanged", v, 2);
        bus_read(2'd2, v); check(v == 9, "R9 count unchanged", v, 9);
        // R2 spare bits read zero
        bus_write(2'd0, 16'h00E0, d);
        bus_read(2'd0, v); check(v == 0, "R2 spare bits zero", v, 0);
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) check(1'b0, "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule